// File: doc/BRIEF.md
# Stereo Automatic Gain Level Controller

This block watches a stereo stream of signed converter samples and keeps one gain-reduction offset that both channels share. Each channel has its own programmed starting gain code, counted in 0.5 dB steps. The effective gain of a channel is that starting code minus the shared offset. The left/right difference is therefore kept, and neither gain rises above its programmed value.

When a sample is too loud, the block enters attack. It raises the offset by one step and then ignores a programmable number of valid samples before it looks at the level again. It keeps stepping for as long as the signal stays too loud. Software chooses one of three recovery policies:
- none: the offset never drops until the block is cleared.
- normal: the offset steps back toward zero once per recovery interval while the signal is quiet.
- limited: like normal, but the offset never goes below a fixed floor.

A single-channel or dual-channel rule decides what "too loud" means.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is high in every cycle, including reset. A sample is consumed in every cycle where `smp_valid` is high, and cycles where `smp_valid` is low have no effect. All other pins are plain control levels or strobes. The gain outputs are registered-offset results and change one clock edge after the sample that caused the change.

Top module: `stereo_alc`

## Requirements
- R1: A channel's level is the magnitude of its two's-complement sample, with the most negative code taken as the largest positive magnitude. A channel is over the attack limit only when its level is strictly greater than `atk_thresh`. It is quiet only when its level is strictly less than `rec_thresh`.
- R2: When `both_sel` is 0, an evaluated sample with either channel over the attack limit raises the offset by one. Both `gain_l` and `gain_r` then drop by exactly one code at the next clock edge.
- R3: When `both_sel` is 1, the offset is raised only when both channels are over the attack limit in the same sample.
- R4: After every offset change, the next N valid samples are ignored, where N is `atk_interval` after an attack step and `rec_interval` after a recovery step. The sample that follows them is evaluated. With N=0, every sample is evaluated.
- R5: `gain_l` equals `init_gain_l` minus the offset, and `gain_r` equals `init_gain_r` minus the offset, so neither output ever exceeds its initial code.
- R6: The offset stops growing at the smaller of `init_gain_l` and `init_gain_r`.
- R7: `rec_mode` encoding is 2'b00 no recovery, 2'b01 normal, 2'b10 limited, and 2'b11 behaves as no recovery. In no-recovery mode the offset never decreases except through R11.
- R8: In normal mode, an evaluated sample with no attack condition and both channels quiet lowers the offset by one, as long as the offset is above zero.
- R9: An evaluated sample that is neither an attack nor quiet on both channels leaves the gains held. Recovery resumes with the next quiet evaluated sample. An offset of zero stays at zero until an attack.
- R10: In limited mode, recovery follows R8 but stops once the offset reaches LIMIT_FLOOR (default 2).
- R11: Holding `alc_enable` low or pulsing `alc_restart` clears the offset and the interval counter at the next edge. This takes priority over any step that is due in the same cycle.
- R12: Samples with `smp_valid` low have no effect. `smp_ready` is always 1.
- R13: After reset the offset is zero, so `gain_l`/`gain_r` equal the initial codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Stereo sample present |
| smp_ready | output | 1 | Always 1; the block never stalls |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| atk_thresh | input | SAMPLE_W-1 | Attack limit magnitude |
| rec_thresh | input | SAMPLE_W-1 | Recovery limit magnitude |
| atk_interval | input | TIMER_W | Valid samples skipped after an attack step |
| rec_interval | input | TIMER_W | Valid samples skipped after a recovery step |
| rec_mode | input | 2 | Recovery policy |
| both_sel | input | 1 | 1: both channels must be over; 0: either channel |
| alc_enable | input | 1 | Low clears and holds the offset at zero |
| alc_restart | input | 1 | One-cycle strobe that clears the offset |
| init_gain_l | input | GAIN_W | Left initial (maximum) gain code |
| init_gain_r | input | GAIN_W | Right initial (maximum) gain code |
| gain_l | output | GAIN_W | Effective left gain code |
| gain_r | output | GAIN_W | Effective right gain code |

## Verification
The clearing path and an attack step can fall in the same cycle. This happens when a loud valid sample arrives while `alc_restart` is high, or while `alc_enable` is low. The bench first builds a non-zero offset, then presents a loud sample together with the restart strobe. It judges the result by requiring both gains to equal the initial codes after that edge, rather than one step below. A second coincidence, the recovery-interval expiry landing on a sample at exactly the recovery limit, is checked by expecting the gains to hold.

// File: rtl/alc_pkg.sv
package alc_pkg;
  typedef enum logic [1:0] {
    REC_NONE    = 2'b00,
    REC_NORMAL  = 2'b01,
    REC_LIMITED = 2'b10,
    REC_RSVD    = 2'b11
  } rec_mode_e;
endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect #(
  parameter int SAMPLE_W = 16,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic [MAG_W-1:0]    atk_thr,
  input  logic [MAG_W-1:0]    rec_thr,
  input  logic                both_sel,
  output logic                over,
  output logic                quiet
);
  logic [1:0] hi;
  logic [1:0] lo;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [SAMPLE_W-1:0] s;
    logic [SAMPLE_W-1:0] neg;
    logic [MAG_W-1:0]    mag;
    assign s   = (c == 0) ? smp_l : smp_r;
    assign neg = -s;
    always_comb begin
      if (!s[SAMPLE_W-1])            mag = s[MAG_W-1:0];
      else if (s[MAG_W-1:0] == '0)   mag = '1;      // most negative code saturates
      else                           mag = neg[MAG_W-1:0];
    end
    assign hi[c] = (mag > atk_thr);
    assign lo[c] = (mag < rec_thr);
  end

  assign over  = both_sel ? (&hi) : (|hi);
  assign quiet = &lo;
endmodule

// File: rtl/alc_interval_timer.sv
module alc_interval_timer #(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               tick,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  output logic               expired
);
  logic [TIMER_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (clear)                    count <= '0;
    else if (load)                     count <= load_val;
    else if (tick && count != '0)      count <= count - 1'b1;
  end

  assign expired = (count == '0);

  // R4: while waiting, each valid sample consumes one slot of the interval
  assert_wait_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !expired && !clear && !load) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/alc_offset_ctrl.sv
module alc_offset_ctrl
  import alc_pkg::*;
#(
  parameter int GAIN_W      = 6,
  parameter int LIMIT_FLOOR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              eval,
  input  logic              over,
  input  logic              quiet,
  input  logic [1:0]        rec_mode,
  input  logic [GAIN_W-1:0] max_off,
  output logic [GAIN_W-1:0] offset,
  output logic              step_dn,
  output logic              step_up
);
  localparam logic [GAIN_W-1:0] FLOOR_CODE = GAIN_W'(LIMIT_FLOOR);

  rec_mode_e         mode;
  logic              rec_ok;
  logic [GAIN_W-1:0] floor_v;

  assign mode = rec_mode_e'(rec_mode);

  always_comb begin
    rec_ok  = 1'b0;
    floor_v = '0;
    case (mode)
      REC_NORMAL:  rec_ok = 1'b1;
      REC_LIMITED: begin rec_ok = 1'b1; floor_v = FLOOR_CODE; end
      default:     rec_ok = 1'b0;
    endcase
  end

  assign step_dn = eval && over && (offset < max_off);
  assign step_up = eval && !over && quiet && rec_ok && (offset > floor_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       offset <= '0;
    else if (clear)   offset <= '0;
    else if (step_dn) offset <= offset + 1'b1;
    else if (step_up) offset <= offset - 1'b1;
  end

  // R2/R8: the offset moves by at most one code per edge unless cleared
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (offset == $past(offset) || offset == $past(offset) + 1'b1 ||
                offset == $past(offset) - 1'b1));
  // R7: no-recovery policies never let the offset fall
  assert_no_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && (rec_mode == REC_NONE || rec_mode == REC_RSVD)) |=> (offset >= $past(offset)));
  // R6: an offset inside its bound stays inside it
  assert_offset_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && offset <= max_off) |=> (offset <= $past(max_off)));
  // R11: clearing wins over any pending step
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (offset == '0));
  // R12: no evaluated sample, no change
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !eval) |=> $stable(offset));
endmodule

// File: rtl/stereo_alc.sv
module stereo_alc #(
  parameter int SAMPLE_W    = 16,
  parameter int GAIN_W      = 6,
  parameter int TIMER_W     = 8,
  parameter int LIMIT_FLOOR = 2,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [MAG_W-1:0]    atk_thresh,
  input  logic [MAG_W-1:0]    rec_thresh,
  input  logic [TIMER_W-1:0]  atk_interval,
  input  logic [TIMER_W-1:0]  rec_interval,
  input  logic [1:0]          rec_mode,
  input  logic                both_sel,
  input  logic                alc_enable,
  input  logic                alc_restart,
  input  logic [GAIN_W-1:0]   init_gain_l,
  input  logic [GAIN_W-1:0]   init_gain_r,
  output logic [GAIN_W-1:0]   gain_l,
  output logic [GAIN_W-1:0]   gain_r
);
  logic              over, quiet, expired, eval, clear;
  logic              step_dn, step_up;
  logic [GAIN_W-1:0] offset, max_off;
  logic [GAIN_W-1:0] init_g [2];
  logic [GAIN_W-1:0] eff_g  [2];

  assign smp_ready = 1'b1;
  assign clear     = !alc_enable || alc_restart;
  assign eval      = smp_valid && expired;
  assign max_off   = (init_gain_l < init_gain_r) ? init_gain_l : init_gain_r;

  alc_level_detect #(.SAMPLE_W(SAMPLE_W)) u_level (
    .smp_l(smp_left), .smp_r(smp_right),
    .atk_thr(atk_thresh), .rec_thr(rec_thresh),
    .both_sel(both_sel), .over(over), .quiet(quiet)
  );

  alc_interval_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tick(smp_valid),
    .load(step_dn || step_up),
    .load_val(step_dn ? atk_interval : rec_interval),
    .expired(expired)
  );

  alc_offset_ctrl #(.GAIN_W(GAIN_W), .LIMIT_FLOOR(LIMIT_FLOOR)) u_offset (
    .clk(clk), .rst_n(rst_n), .clear(clear), .eval(eval),
    .over(over), .quiet(quiet), .rec_mode(rec_mode), .max_off(max_off),
    .offset(offset), .step_dn(step_dn), .step_up(step_up)
  );

  assign init_g[0] = init_gain_l;
  assign init_g[1] = init_gain_r;

  for (genvar c = 0; c < 2; c++) begin : g_gain
    assign eff_g[c] = (init_g[c] > offset) ? (init_g[c] - offset) : '0;
  end

  assign gain_l = eff_g[0];
  assign gain_r = eff_g[1];

  // R5: an output never rises above its programmed start code
  assert_gain_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l <= init_gain_l) && (gain_r <= init_gain_r));
endmodule

// File: tb/test_stereo_alc.sv
`timescale 1ns/1ps
module test_stereo_alc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic [14:0] atk_thresh = 15'd1000, rec_thresh = 15'd200;
  logic [7:0]  atk_interval = 8'd1, rec_interval = 8'd2;
  logic [1:0]  rec_mode = 2'b01;
  logic        both_sel = 1'b0, alc_enable = 1'b1, alc_restart = 1'b0;
  logic [5:0]  init_gain_l = 6'd10, init_gain_r = 6'd7;
  logic [5:0]  gain_l, gain_r;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stereo_alc i_stereo_alc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right),
    .atk_thresh(atk_thresh), .rec_thresh(rec_thresh),
    .atk_interval(atk_interval), .rec_interval(rec_interval),
    .rec_mode(rec_mode), .both_sel(both_sel),
    .alc_enable(alc_enable), .alc_restart(alc_restart),
    .init_gain_l(init_gain_l), .init_gain_r(init_gain_r),
    .gain_l(gain_l), .gain_r(gain_r)
  );

  // {left, right, expected gain_l, expected gain_r}; start codes 10/7,
  // attack limit 1000, recovery limit 200, intervals 1/2, normal recovery
  localparam int NV = 13;
  localparam logic [43:0] VEC [NV] = '{
    {16'h07D0, 16'h0000, 6'd9,  6'd6},   // R2 attack on left
    {16'h07D0, 16'h0000, 6'd9,  6'd6},   // R4 skipped
    {16'hF830, 16'h0000, 6'd8,  6'd5},   // R1 negative sample
    {16'h0000, 16'h0000, 6'd8,  6'd5},   // R4 skipped
    {16'h01F4, 16'h0000, 6'd8,  6'd5},   // R9 hold between limits
    {16'h0064, 16'hFF9C, 6'd9,  6'd6},   // R8 recovery
    {16'h0064, 16'h0000, 6'd9,  6'd6},
    {16'h0064, 16'h0000, 6'd9,  6'd6},
    {16'h0064, 16'h0000, 6'd10, 6'd7},   // R8 second step
    {16'h0000, 16'h0000, 6'd10, 6'd7},
    {16'h0000, 16'h0000, 6'd10, 6'd7},
    {16'h0000, 16'h0000, 6'd10, 6'd7},   // R9 stays at zero offset
    {16'h0000, 16'h8000, 6'd9,  6'd6}    // R1 most negative code
  };

  task automatic check(input string req, input logic [5:0] el, input logic [5:0] er);
    total++;
    if (gain_l !== el || gain_r !== er) begin
      bad++;
      $display("FAIL %s: gain_l=%0d gain_r=%0d expected %0d %0d", req, gain_l, gain_r, el, er);
    end
  endtask

  task automatic send(input logic [15:0] l, input logic [15:0] r, input logic v);
    @(negedge clk);
    smp_left = l; smp_right = r; smp_valid = v;
    @(negedge clk);
    smp_valid = 1'b0; alc_restart = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); alc_restart = 1'b1;
    @(negedge clk); alc_restart = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset", 6'd10, 6'd7);
    total++;
    if (smp_ready !== 1'b1) begin bad++; $display("FAIL R12 ready=%b expected 1", smp_ready); end
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 after reset", 6'd10, 6'd7);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][43:28], VEC[i][27:12], 1'b1);
      check($sformatf("vector %0d", i), VEC[i][11:6], VEC[i][5:0]);
    end

    // R1 boundaries, interval zero
    atk_interval = 8'd0; rec_interval = 8'd0;
    restart();
    send(16'd1000, 16'd0, 1'b1);  check("R1 equal to attack limit", 6'd10, 6'd7);
    send(-16'sd1001, 16'd0, 1'b1); check("R1 just over limit", 6'd9, 6'd6);
    send(16'd200, 16'd0, 1'b1);   check("R9 equal to recovery limit holds", 6'd9, 6'd6);
    send(16'd199, 16'd0, 1'b1);   check("R8 below recovery limit", 6'd10, 6'd7);

    // R12 invalid sample ignored
    send(16'd5000, 16'd5000, 1'b0); check("R12 valid low", 6'd10, 6'd7);

    // R3 both-channel rule, R7 no recovery
    rec_mode = 2'b00; both_sel = 1'b1;
    restart();
    send(16'd2000, 16'd0, 1'b1);     check("R3 one channel only", 6'd10, 6'd7);
    send(16'd2000, 16'hF830, 1'b1);  check("R3 both channels", 6'd9, 6'd6);
    both_sel = 1'b0;
    for (int i = 0; i < 3; i++) send(16'd0, 16'd0, 1'b1);
    check("R7 no recovery", 6'd9, 6'd6);
    rec_mode = 2'b11;
    send(16'd0, 16'd0, 1'b1);        check("R7 reserved code", 6'd9, 6'd6);
    restart();                       check("R11 restart strobe", 6'd10, 6'd7);

    // R11 enable toggle and enable low
    send(16'd3000, 16'd0, 1'b1);     check("R2 attack before toggle", 6'd9, 6'd6);
    @(negedge clk) alc_enable = 1'b0;
    send(16'd3000, 16'd0, 1'b1);     check("R11 enable low", 6'd10, 6'd7);
    alc_enable = 1'b1;

    // R11 restart coinciding with an attack step
    send(16'd3000, 16'd0, 1'b1);     check("R2 attack before coincide", 6'd9, 6'd6);
    @(negedge clk);
    smp_left = 16'd3000; smp_right = 16'd0; smp_valid = 1'b1; alc_restart = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; alc_restart = 1'b0;
    check("R11 restart beats attack", 6'd10, 6'd7);

    // R6 saturation at smaller start code
    rec_mode = 2'b00;
    for (int i = 0; i < 9; i++) send(16'd4000, 16'd4000, 1'b1);
    check("R6 saturation", 6'd3, 6'd0);

    // R10 limited recovery floor
    rec_mode = 2'b10;
    for (int i = 0; i < 8; i++) send(16'd0, 16'd0, 1'b1);
    check("R10 limited floor", 6'd8, 6'd5);

    // R4 longer attack interval
    rec_mode = 2'b00; atk_interval = 8'd3;
    restart();
    send(16'd4000, 16'd0, 1'b1);
    for (int i = 0; i < 3; i++) send(16'd4000, 16'd0, 1'b1);
    check("R4 interval skips", 6'd9, 6'd6);
    send(16'd4000, 16'd0, 1'b1);     check("R4 evaluated after interval", 6'd8, 6'd5);

    finished = 1'b1;
    finish_run();
  end
endmodule